// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block collects the interrupt traffic a PCIe root port receives from its link and turns it into one level interrupt for the CPU. Legacy INTx assert and deassert messages, MSI writes, and two link housekeeping events (power-state change and flush) arrive as already-decoded single-cycle strobes. Each event sets a sticky bit in a write-one-to-clear status register. Each status register has a mask register beside it, in which a 1 hides the bit.

The block has two levels. The first level holds the INTx bits and an MSI-pending bit. Beside it sits a small auxiliary register for the power and flush events. Any unmasked bit in either of these sets a core-interrupt bit in a top-level summary register. The top level has its own mask, and it drives the CPU interrupt line. MSI writes land in a 32-vector status word with its own mask. The low byte of the last MSI data word is kept in a read-only payload register. Software reads the registers through a simple single-cycle register port. It services the vectors, then clears from the innermost level outward.

Top module: `pcie_irq_aggr`

## Requirements
- R1: A strobe on INTx assert line i (i = 0..3, lines A..D) sets bit 16+i of the first-level status (word 0). A strobe on deassert line i sets bit 20+i.
- R2: An MSI strobe with vector v sets bit v of the MSI status (word 4). The payload register (word 6, read-only) then reads the low 8 bits of that strobe's data, zero-extended.
- R3: Bit 24 of the first-level status is set one cycle after any MSI status bit is set while its MSI mask bit (word 5) is 0. A masked vector never sets it.
- R4: Every status register (words 0, 2, 4, 7) is write-one-to-clear per bit. Writing 0 to a bit leaves it unchanged.
- R5: When an event sets a status bit in the same cycle that software writes 1 to clear it, the bit stays set.
- R6: Bit 16 of the top-level status (word 7) is set one cycle after either of two conditions holds. The first is that first-level status AND NOT first-level mask (word 1) is nonzero within bits 26:0. The second is that auxiliary status AND NOT auxiliary mask (word 3) is nonzero.
- R7: A power-state-change strobe sets bit 4 of the auxiliary status (word 2). A flush strobe sets bit 5.
- R8: irq_o is high exactly while top-level status AND NOT top-level mask (word 8) is nonzero. The top-level mask can only hold the bits 0x00FFF0FB.
- R9: After reset all status words and the payload read 0. The masks read as follows: word 1 reads 0x07FFFFFF, word 3 reads 0x30, word 5 reads 0xFFFFFFFF and word 8 reads 0x00FFF0FB. irq_o is low.
- R10: Writes have no effect on bits outside each register's valid set: 26:0 for the first level, 5:4 for the auxiliary register and 0x00FFF0FB for the top level. Writes to the payload word, and to unmapped words, have no effect. Such bits always read 0, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_assert_i | input | 4 | INTx assert strobes, lines A..D |
| intx_deassert_i | input | 4 | INTx deassert strobes, lines A..D |
| msi_valid_i | input | 1 | Decoded MSI write strobe |
| msi_vec_i | input | 5 | MSI vector number |
| msi_data_i | input | 16 | MSI data word |
| pwr_chg_i | input | 1 | Power-state change strobe |
| flush_i | input | 1 | Flush event strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| irq_o | output | 1 | Level interrupt to the CPU |

## Verification
If a status bit is wrongly stuck, a bit is lost, or a mask bit is corrupted, the wrong value shows up on the next register read of that word. Two cycles after an INTx event and three after an MSI write, it also shows up on irq_o. Such a fault drives irq_o high when it should be low, or the reverse, as soon as the bad value reaches the top level. A cleared bit that was lost to a same-cycle event would show as a missing interrupt. The bench therefore checks both the register images and the interrupt line after every random burst. Directed cases cover the one-cycle and two-cycle edges of the cascade.

// File: rtl/pia_pkg.sv
package pia_pkg;
    localparam int REG_W = 32;

    typedef enum logic [3:0] {
        A_L1_ST   = 4'd0,
        A_L1_MK   = 4'd1,
        A_AUX_ST  = 4'd2,
        A_AUX_MK  = 4'd3,
        A_MSI_ST  = 4'd4,
        A_MSI_MK  = 4'd5,
        A_MSI_PAY = 4'd6,
        A_TOP_ST  = 4'd7,
        A_TOP_MK  = 4'd8
    } reg_addr_e;

    localparam logic [REG_W-1:0] L1_VALID  = 32'h07FF_FFFF;
    localparam logic [REG_W-1:0] AUX_VALID = 32'h0000_0030;
    localparam logic [REG_W-1:0] TOP_VALID = 32'h00FF_F0FB;

    localparam int INTX_AS_LSB   = 16;
    localparam int INTX_DE_LSB   = 20;
    localparam int MSI_PEND_BIT  = 24;
    localparam int AUX_PWR_BIT   = 4;
    localparam int AUX_FLUSH_BIT = 5;
    localparam int TOP_CORE_BIT  = 16;

    typedef struct packed {
        logic [3:0] assert_s;
        logic [3:0] deassert_s;
    } intx_evt_t;

    function automatic logic any_unmasked(input logic [REG_W-1:0] st,
                                          input logic [REG_W-1:0] mk,
                                          input logic [REG_W-1:0] valid);
        return |(st & ~mk & valid);
    endfunction
endpackage

// File: rtl/pia_status_reg.sv
module pia_status_reg #(
    parameter int          W     = 32,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] st_o
);
    always_ff @(posedge clk) begin
        if (rst) st_o <= '0;
        else     st_o <= ((st_o & ~clr_i) | set_i) & VALID;
    end
endmodule

// File: rtl/pia_mask_reg.sv
module pia_mask_reg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] VALID   = '1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mk_o
);
    always_ff @(posedge clk) begin
        if (rst)       mk_o <= RST_VAL & VALID;
        else if (we_i) mk_o <= wdata_i & VALID;
    end
endmodule

// File: rtl/pia_msi_capture.sv
module pia_msi_capture #(
    parameter int NUM_MSI    = 32,
    parameter int MSI_DATA_W = 16,
    parameter int PAY_W      = 8,
    localparam int VEC_W     = $clog2(NUM_MSI)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  valid_i,
    input  logic [VEC_W-1:0]      vec_i,
    input  logic [MSI_DATA_W-1:0] data_i,
    input  logic [NUM_MSI-1:0]    st_clr_i,
    input  logic                  mk_we_i,
    input  logic [NUM_MSI-1:0]    mk_wdata_i,
    output logic [NUM_MSI-1:0]    st_o,
    output logic [NUM_MSI-1:0]    mk_o,
    output logic [PAY_W-1:0]      payload_o,
    output logic                  pend_o
);
    logic [NUM_MSI-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (valid_i) set_vec = NUM_MSI'(1) << vec_i;
    end

    pia_status_reg #(.W(NUM_MSI), .VALID({NUM_MSI{1'b1}})) u_st (
        .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(st_clr_i), .st_o(st_o)
    );

    pia_mask_reg #(.W(NUM_MSI), .VALID({NUM_MSI{1'b1}}), .RST_VAL({NUM_MSI{1'b1}})) u_mk (
        .clk(clk), .rst(rst), .we_i(mk_we_i), .wdata_i(mk_wdata_i), .mk_o(mk_o)
    );

    always_ff @(posedge clk) begin
        if (rst)          payload_o <= '0;
        else if (valid_i) payload_o <= data_i[PAY_W-1:0];
    end

    assign pend_o = |(st_o & ~mk_o);
endmodule

// File: rtl/pia_summary.sv
module pia_summary
    import pia_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             core_evt_i,
    input  logic [REG_W-1:0] st_clr_i,
    input  logic             mk_we_i,
    input  logic [REG_W-1:0] mk_wdata_i,
    output logic [REG_W-1:0] st_o,
    output logic [REG_W-1:0] mk_o,
    output logic             irq_o
);
    logic [REG_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        set_vec[TOP_CORE_BIT] = core_evt_i;
    end

    pia_status_reg #(.W(REG_W), .VALID(TOP_VALID)) u_st (
        .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(st_clr_i), .st_o(st_o)
    );

    pia_mask_reg #(.W(REG_W), .VALID(TOP_VALID), .RST_VAL(TOP_VALID)) u_mk (
        .clk(clk), .rst(rst), .we_i(mk_we_i), .wdata_i(mk_wdata_i), .mk_o(mk_o)
    );

    assign irq_o = any_unmasked(st_o, mk_o, TOP_VALID);
endmodule

// File: rtl/pcie_irq_aggr.sv
module pcie_irq_aggr
    import pia_pkg::*;
#(
    parameter int NUM_INTX   = 4,
    parameter int NUM_MSI    = 32,
    parameter int MSI_DATA_W = 16,
    parameter int PAY_W      = 8,
    parameter int ADDR_W     = 4,
    localparam int VEC_W     = $clog2(NUM_MSI)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_INTX-1:0]   intx_assert_i,
    input  logic [NUM_INTX-1:0]   intx_deassert_i,
    input  logic                  msi_valid_i,
    input  logic [VEC_W-1:0]      msi_vec_i,
    input  logic [MSI_DATA_W-1:0] msi_data_i,
    input  logic                  pwr_chg_i,
    input  logic                  flush_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o,
    output logic                  irq_o
);
    intx_evt_t        intx_evt;
    logic [REG_W-1:0] l1_set, l1_clr, l1_st, l1_mk;
    logic [REG_W-1:0] aux_set, aux_clr, aux_st, aux_mk;
    logic [REG_W-1:0] top_clr, top_st, top_mk;
    logic [NUM_MSI-1:0] msi_clr, msi_st, msi_mk;
    logic [PAY_W-1:0] msi_pay;
    logic             msi_pend;
    logic             core_evt;

    function automatic logic sel(input logic [ADDR_W-1:0] a, input reg_addr_e which);
        return a == ADDR_W'(which);
    endfunction

    always_comb begin
        intx_evt = '0;
        intx_evt.assert_s[NUM_INTX-1:0]   = intx_assert_i;
        intx_evt.deassert_s[NUM_INTX-1:0] = intx_deassert_i;
    end

    // first-level event vector
    always_comb begin
        l1_set = '0;
        l1_set[MSI_PEND_BIT] = msi_pend;
    end
    logic [REG_W-1:0] l1_intx;
    genvar gi;
    generate
        for (gi = 0; gi < 4; gi++) begin : g_intx
            always_comb begin
                l1_intx[INTX_AS_LSB+gi] = intx_evt.assert_s[gi];
                l1_intx[INTX_DE_LSB+gi] = intx_evt.deassert_s[gi];
            end
        end
    endgenerate
    always_comb begin
        for (int b = 0; b < INTX_AS_LSB; b++) l1_intx[b] = 1'b0;
        for (int b = INTX_DE_LSB + 4; b < REG_W; b++) l1_intx[b] = 1'b0;
    end

    always_comb begin
        aux_set = '0;
        aux_set[AUX_PWR_BIT]   = pwr_chg_i;
        aux_set[AUX_FLUSH_BIT] = flush_i;
    end

    // write-one-to-clear decode
    assign l1_clr  = (reg_we_i && sel(reg_addr_i, A_L1_ST))  ? reg_wdata_i : '0;
    assign aux_clr = (reg_we_i && sel(reg_addr_i, A_AUX_ST)) ? reg_wdata_i : '0;
    assign top_clr = (reg_we_i && sel(reg_addr_i, A_TOP_ST)) ? reg_wdata_i : '0;
    assign msi_clr = (reg_we_i && sel(reg_addr_i, A_MSI_ST)) ? reg_wdata_i[NUM_MSI-1:0] : '0;

    pia_status_reg #(.W(REG_W), .VALID(L1_VALID)) u_l1_st (
        .clk(clk), .rst(rst), .set_i(l1_set | l1_intx), .clr_i(l1_clr), .st_o(l1_st)
    );
    pia_mask_reg #(.W(REG_W), .VALID(L1_VALID), .RST_VAL(L1_VALID)) u_l1_mk (
        .clk(clk), .rst(rst), .we_i(reg_we_i && sel(reg_addr_i, A_L1_MK)),
        .wdata_i(reg_wdata_i), .mk_o(l1_mk)
    );

    pia_status_reg #(.W(REG_W), .VALID(AUX_VALID)) u_aux_st (
        .clk(clk), .rst(rst), .set_i(aux_set), .clr_i(aux_clr), .st_o(aux_st)
    );
    pia_mask_reg #(.W(REG_W), .VALID(AUX_VALID), .RST_VAL(AUX_VALID)) u_aux_mk (
        .clk(clk), .rst(rst), .we_i(reg_we_i && sel(reg_addr_i, A_AUX_MK)),
        .wdata_i(reg_wdata_i), .mk_o(aux_mk)
    );

    pia_msi_capture #(.NUM_MSI(NUM_MSI), .MSI_DATA_W(MSI_DATA_W), .PAY_W(PAY_W)) u_msi (
        .clk(clk), .rst(rst),
        .valid_i(msi_valid_i), .vec_i(msi_vec_i), .data_i(msi_data_i),
        .st_clr_i(msi_clr),
        .mk_we_i(reg_we_i && sel(reg_addr_i, A_MSI_MK)),
        .mk_wdata_i(reg_wdata_i[NUM_MSI-1:0]),
        .st_o(msi_st), .mk_o(msi_mk), .payload_o(msi_pay), .pend_o(msi_pend)
    );

    assign core_evt = any_unmasked(l1_st, l1_mk, L1_VALID) |
                      any_unmasked(aux_st, aux_mk, AUX_VALID);

    pia_summary u_top (
        .clk(clk), .rst(rst), .core_evt_i(core_evt),
        .st_clr_i(top_clr),
        .mk_we_i(reg_we_i && sel(reg_addr_i, A_TOP_MK)),
        .mk_wdata_i(reg_wdata_i),
        .st_o(top_st), .mk_o(top_mk), .irq_o(irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if      (sel(reg_addr_i, A_L1_ST))   reg_rdata_o = l1_st;
        else if (sel(reg_addr_i, A_L1_MK))   reg_rdata_o = l1_mk;
        else if (sel(reg_addr_i, A_AUX_ST))  reg_rdata_o = aux_st;
        else if (sel(reg_addr_i, A_AUX_MK))  reg_rdata_o = aux_mk;
        else if (sel(reg_addr_i, A_MSI_ST))  reg_rdata_o = REG_W'(msi_st);
        else if (sel(reg_addr_i, A_MSI_MK))  reg_rdata_o = REG_W'(msi_mk);
        else if (sel(reg_addr_i, A_MSI_PAY)) reg_rdata_o = REG_W'(msi_pay);
        else if (sel(reg_addr_i, A_TOP_ST))  reg_rdata_o = top_st;
        else if (sel(reg_addr_i, A_TOP_MK))  reg_rdata_o = top_mk;
    end
endmodule

// File: rtl/pia_chk.sv
module pia_chk
    import pia_pkg::*;
#(
    parameter int NUM_MSI = 32,
    parameter int PAY_W   = 8,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [3:0]         intx_assert,
    input logic               msi_valid,
    input logic [15:0]        msi_data,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   l1_st,
    input logic [REG_W-1:0]   l1_mk,
    input logic [NUM_MSI-1:0] msi_st,
    input logic [NUM_MSI-1:0] msi_mk,
    input logic [PAY_W-1:0]   payload,
    input logic [REG_W-1:0]   top_st,
    input logic               irq
);
    p_intx_set_r1: assert property (@(posedge clk) disable iff (rst)
        intx_assert[0] |=> l1_st[INTX_AS_LSB]);

    p_msi_set_r2: assert property (@(posedge clk) disable iff (rst)
        msi_valid |=> (msi_st != '0) && (payload == $past(msi_data[PAY_W-1:0])));

    p_msi_pend_r3: assert property (@(posedge clk) disable iff (rst)
        (|(msi_st & ~msi_mk)) |=> l1_st[MSI_PEND_BIT]);

    p_w1c_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(A_L1_ST) && reg_wdata[INTX_AS_LSB+1] && !intx_assert[1])
        |=> !l1_st[INTX_AS_LSB+1]);

    p_core_set_r6: assert property (@(posedge clk) disable iff (rst)
        (|(l1_st & ~l1_mk & L1_VALID)) |=> top_st[TOP_CORE_BIT]);

    p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (top_st != '0));

    p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);
endmodule

bind pcie_irq_aggr pia_chk #(.NUM_MSI(NUM_MSI), .PAY_W(PAY_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .intx_assert(intx_assert_i[3:0]), .msi_valid(msi_valid_i),
    .msi_data(msi_data_i[15:0]), .reg_we(reg_we_i), .reg_addr(reg_addr_i),
    .reg_wdata(reg_wdata_i), .l1_st(l1_st), .l1_mk(l1_mk), .msi_st(msi_st),
    .msi_mk(msi_mk), .payload(msi_pay), .top_st(top_st), .irq(irq_o)
);

// File: tb/sim_pcie_irq_aggr.sv
module sim_pcie_irq_aggr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ia = '0, id = '0;
    logic        mv = 1'b0;
    logic [4:0]  mvec = '0;
    logic [15:0] mdat = '0;
    logic        pwr = 1'b0, fl = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pcie_irq_aggr u0 (
        .clk(clk), .rst(rst), .intx_assert_i(ia), .intx_deassert_i(id),
        .msi_valid_i(mv), .msi_vec_i(mvec), .msi_data_i(mdat),
        .pwr_chg_i(pwr), .flush_i(fl), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    localparam logic [31:0] L1V = 32'h07FF_FFFF, AUXV = 32'h30, TOPV = 32'h00FF_F0FB;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic core_exp(input logic [31:0] l1, input logic [31:0] l1m,
                                      input logic [31:0] ax, input logic [31:0] axm);
        return (|(l1 & ~l1m & L1V)) || (|(ax & ~axm & AUXV));
    endfunction

    task automatic clear_all();
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd7, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp_pay;
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset image
        rd(4'd0, v); chk("R9 l1 status", v, 32'h0);
        rd(4'd1, v); chk("R9 l1 mask", v, 32'h07FF_FFFF);
        rd(4'd2, v); chk("R9 aux status", v, 32'h0);
        rd(4'd3, v); chk("R9 aux mask", v, 32'h30);
        rd(4'd4, v); chk("R9 msi status", v, 32'h0);
        rd(4'd5, v); chk("R9 msi mask", v, 32'hFFFF_FFFF);
        rd(4'd6, v); chk("R9 payload", v, 32'h0);
        rd(4'd7, v); chk("R9 top status", v, 32'h0);
        rd(4'd8, v); chk("R9 top mask", v, TOPV);
        chk("R9 irq", {31'b0, irq}, 32'h0);
        exp_pay = 0;

        // R10 out-of-range bits ignored
        wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v); chk("R10 l1 mask width", v, L1V);
        wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, v); chk("R10 top mask width", v, TOPV);
        wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, v); chk("R10 aux mask width", v, AUXV);
        wr(4'd6, 32'h0000_00AB); rd(4'd6, v); chk("R10 payload read-only", v, 32'h0);
        wr(4'd9, 32'hFFFF_FFFF); rd(4'd9, v); chk("R10 unmapped reads zero", v, 32'h0);

        // R1 / R6 latency: unmask INTA at first level and core at top
        wr(4'd1, L1V & ~32'h0001_0000);
        wr(4'd8, TOPV & ~32'h0001_0000);
        @(negedge clk); ia = 4'b0001;
        @(negedge clk); ia = 4'b0000; addr = 4'd7; #1;
        chk("R6 core not yet set after one edge", rdata, 32'h0);
        addr = 4'd0; #1; chk("R1 INTA sets bit16", rdata, 32'h0001_0000);
        @(negedge clk); addr = 4'd7; #1;
        chk("R6 core set after two edges", rdata, 32'h0001_0000);
        chk("R8 irq high", {31'b0, irq}, 32'h1);

        // R8 top mask hides it
        wr(4'd8, TOPV); chk("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(4'd8, TOPV & ~32'h0001_0000);

        // R4 partial clear; R1 deassert
        @(negedge clk); ia = 4'b0010; id = 4'b1000;
        @(negedge clk); ia = '0; id = '0;
        wr(4'd0, 32'h0001_0000);
        rd(4'd0, v); chk("R4 only written bit clears", v, 32'h0082_0000);

        // R5 same-cycle event vs clear
        @(negedge clk); ia = 4'b0100; we = 1'b1; addr = 4'd0; wdata = 32'h0004_0000;
        @(negedge clk); ia = '0; we = 1'b0;
        rd(4'd0, v); chk("R5 event wins over clear", v & 32'h0004_0000, 32'h0004_0000);

        // R7 aux events
        clear_all();
        @(negedge clk); pwr = 1'b1;
        @(negedge clk); pwr = 1'b0; fl = 1'b1;
        @(negedge clk); fl = 1'b0;
        rd(4'd2, v); chk("R7 aux bits", v, 32'h30);

        // R3 masked MSI does not raise pending
        clear_all();
        wr(4'd5, 32'hFFFF_FFFF);
        @(negedge clk); mv = 1'b1; mvec = 5'd7; mdat = 16'h12C3;
        @(negedge clk); mv = 1'b0; exp_pay = 32'hC3;
        idle(3);
        rd(4'd4, v); chk("R2 msi vector 7", v, 32'h80);
        rd(4'd6, v); chk("R2 payload low byte", v, exp_pay);
        rd(4'd0, v); chk("R3 masked msi no pending", v & 32'h0100_0000, 32'h0);
        wr(4'd5, ~32'h80); idle(2);
        rd(4'd0, v); chk("R3 unmasked msi pending", v & 32'h0100_0000, 32'h0100_0000);

        // random bursts
        for (int it = 0; it < 40; it++) begin
            logic [31:0] l1m, axm, msm, tpm, e_msi, e_l1, e_aux, e_top;
            logic [3:0] e_a, e_d;
            l1m = $urandom & L1V;
            axm = $urandom & AUXV;
            msm = $urandom;
            tpm = $urandom & TOPV;
            wr(4'd5, msm); wr(4'd1, l1m); wr(4'd3, axm); wr(4'd8, tpm);
            clear_all();
            e_msi = 0; e_a = 0; e_d = 0; e_aux = 0;
            for (int k = 0; k < 1 + ($urandom % 6); k++) begin
                int kind;
                kind = $urandom % 5;
                @(negedge clk);
                case (kind)
                    0: begin ia[$urandom % 4] = 1'b1; end
                    1: begin id[$urandom % 4] = 1'b1; end
                    2: begin mv = 1'b1; mvec = 5'($urandom); mdat = 16'($urandom); end
                    3: pwr = 1'b1;
                    default: fl = 1'b1;
                endcase
                e_a |= ia; e_d |= id;
                if (mv) begin e_msi |= 32'h1 << mvec; exp_pay = {24'h0, mdat[7:0]}; end
                if (pwr) e_aux |= 32'h10;
                if (fl)  e_aux |= 32'h20;
                @(negedge clk); ia = '0; id = '0; mv = 1'b0; pwr = 1'b0; fl = 1'b0;
            end
            idle(4);
            e_l1 = ({28'h0, e_a} << 16) | ({28'h0, e_d} << 20) |
                   ((|(e_msi & ~msm)) ? 32'h0100_0000 : 32'h0);
            e_top = core_exp(e_l1, l1m, e_aux, axm) ? 32'h0001_0000 : 32'h0;
            rd(4'd4, v); chk("R2 random msi status", v, e_msi);
            rd(4'd6, v); chk("R2 random payload", v, exp_pay);
            rd(4'd0, v); chk("R1 R3 random l1 status", v, e_l1);
            rd(4'd2, v); chk("R7 random aux status", v, e_aux);
            rd(4'd7, v); chk("R6 random top status", v, e_top);
            chk("R8 random irq", {31'b0, irq}, {31'b0, |(e_top & ~tpm)});
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule